// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that runs from its own slow clock, so it keeps counting if the system bus clock dies. Software reaches it through four word registers on a simple synchronous bus. It controls the watchdog only by writing magic values to a key register. One value starts the count. One value opens the prescaler and reload registers for writing. One value refreshes the counter from the reload register. Once started, nothing but the block reset stops the count or drops its request for the slow oscillator.

The prescaler and reload values live in the bus clock domain. They are handed to the slow domain through a toggle handshake. While a handoff is in flight, a status bit stays set and further writes to that register are ignored. A 12-bit down-counter ticks once per prescaled period. The watchdog reset output is asserted when the counter reaches zero while the watchdog runs. A debug freeze input, combined with a core-halted input, holds the counter. A strap input starts the watchdog straight out of reset.

Top module: `wdt_top`

## Requirements
- R1: After reset, a read returns 0 at offset 0x0 (key), 0 at 0x4 (prescaler), 0xFFF at 0x8 (reload) and 0 at 0xC (status). `wdReset` and `oscReq` are low while `hwStart` is low. The byte address is `busAddr`; bits [3:2] pick the register.
- R2: A key write whose low 16 bits are 0xCCCC starts the watchdog and raises `oscReq`. After that, no key write (0x0000, 0x1234 or a repeated start) stops the count or lowers `oscReq`. Only `rst_n` does.
- R3: A key write whose low 16 bits are 0x5555 opens the lock. Any other key write closes it, including the refresh and start keys. Writes to the prescaler or reload register while the lock is closed leave the register unchanged.
- R4: A key write whose low 16 bits are 0xAAAA loads the current reload value into the counter and restarts the prescaler phase. Refreshes made more often than the timeout keep `wdReset` low.
- R5: The 12-bit counter decrements once per prescaled period while running. `wdReset` goes high when the count is zero and the watchdog is started. From a refresh with reload R and divide D, this happens after R*D to R*D+8 slow-clock cycles.
- R6: The prescaler field is bits [2:0], and the reload field is bits [11:0]. Code c selects divide 4<<c for c = 0 to 6, and code 7 also selects 256. A read returns the code as written.
- R7: Status bit 0 is set by an accepted prescaler write, and status bit 1 by an accepted reload write. Each bit clears within 40 bus cycles in the bench clocking. A write to a register whose status bit is set is ignored.
- R8: While both `dbgFreeze` and `coreHalted` are high, the counter and the prescaler phase hold. Either input alone does not stop the count.
- R9: With `hwStart` high, the watchdog starts after reset with no key write. It counts from 0xFFF at divide 4, so it times out after about 16380 slow-clock cycles.
- R10: Key values are compared on the low 16 bits only. A key write of 0xFFFF5555 opens the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock for the register file |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | High for a write access |
| busAddr | input | 4 | Byte address; bits [3:2] select the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed register |
| wdClk | input | 1 | Slow clock of the counter domain |
| hwStart | input | 1 | Strap that starts the watchdog out of reset |
| dbgFreeze | input | 1 | Debug freeze enable, synchronous to `wdClk` |
| coreHalted | input | 1 | Core halted indication, synchronous to `wdClk` |
| wdReset | output | 1 | Watchdog reset request |
| oscReq | output | 1 | Request that keeps the slow oscillator on |

## Verification
The timeout is timed for every prescaler code (0 to 7) at a fixed reload. Adjacent divide ratios differ by a factor of two, so the timeout windows never overlap, and codes 6 and 7 must agree. Extra reload values at one code separate reload handling from prescaler handling. Register sequences show the lock rules: writes with the lock closed, the lock reclosed by a refresh key, a key with junk in the high half, and a second write while a handoff is busy. Each of these leaves a different read-back value. The freeze, no-start, periodic-refresh and strap cases each decide whether `wdReset` may rise within a given window.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 4;
  localparam int KEY_W  = 16;
  localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_KICK   = 16'hAAAA;

  // Level toggles carried from the bus domain to the counter domain;
  // each flip is one command or one value handoff.
  typedef struct packed {
    logic startTgl;
    logic kickTgl;
    logic prTgl;
    logic rlTgl;
  } wdtXfer_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int PR_W        = 3,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32
) (
  input  logic              busClk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              prAck,
  input  logic              rlAck,
  output wdtXfer_t          xfer,
  output logic [PR_W-1:0]   prVal,
  output logic [CNT_W-1:0]  rlVal
);
  localparam logic [1:0] IDX_KEY = 2'd0;
  localparam logic [1:0] IDX_PR  = 2'd1;
  localparam logic [1:0] IDX_RL  = 2'd2;
  localparam logic [1:0] IDX_SR  = 2'd3;

  wdtXfer_t                xferQ;
  logic                    unlockQ;
  logic [PR_W-1:0]         prShadow;
  logic [CNT_W-1:0]        rlShadow;
  logic [SYNC_STAGES-1:0]  prAckSync;
  logic [SYNC_STAGES-1:0]  rlAckSync;
  logic                    prBusy;
  logic                    rlBusy;
  logic                    wrEn;
  logic [1:0]              word;
  logic [KEY_W-1:0]        keyVal;
  logic                    keyWr;
  logic                    unusedBits;

  assign wrEn   = busSel & busWr;
  assign word   = busAddr[3:2];
  assign keyVal = busWdata[KEY_W-1:0];
  assign keyWr  = wrEn && (word == IDX_KEY);
  assign unusedBits = ^{busWdata[DATA_W-1:KEY_W], busAddr[1:0]};

  // Acknowledge levels come back from the slow domain.
  always_ff @(posedge busClk or negedge rst_n) begin
    if (!rst_n) begin
      prAckSync <= '0;
      rlAckSync <= '0;
    end else begin
      prAckSync <= {prAckSync[SYNC_STAGES-2:0], prAck};
      rlAckSync <= {rlAckSync[SYNC_STAGES-2:0], rlAck};
    end
  end

  assign prBusy = xferQ.prTgl ^ prAckSync[SYNC_STAGES-1];
  assign rlBusy = xferQ.rlTgl ^ rlAckSync[SYNC_STAGES-1];

  always_ff @(posedge busClk or negedge rst_n) begin
    if (!rst_n) begin
      unlockQ  <= 1'b0;
      xferQ    <= '0;
      prShadow <= '0;
      rlShadow <= '1;
    end else begin
      if (keyWr) begin
        unlockQ <= (keyVal == KEY_UNLOCK);
        if (keyVal == KEY_START) xferQ.startTgl <= ~xferQ.startTgl;
        if (keyVal == KEY_KICK)  xferQ.kickTgl  <= ~xferQ.kickTgl;
      end
      if (wrEn && word == IDX_PR && unlockQ && !prBusy) begin
        prShadow    <= busWdata[PR_W-1:0];
        xferQ.prTgl <= ~xferQ.prTgl;
      end
      if (wrEn && word == IDX_RL && unlockQ && !rlBusy) begin
        rlShadow    <= busWdata[CNT_W-1:0];
        xferQ.rlTgl <= ~xferQ.rlTgl;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    case (word)
      IDX_PR:  busRdata[PR_W-1:0]  = prShadow;
      IDX_RL:  busRdata[CNT_W-1:0] = rlShadow;
      IDX_SR:  busRdata[1:0]       = {rlBusy, prBusy};
      default: busRdata = '0;
    endcase
  end

  assign xfer  = xferQ;
  assign prVal = prShadow;
  assign rlVal = rlShadow;

  // R3: with the lock closed, neither protected register can change
  a_r3_locked_stable: assert property (@(posedge busClk) disable iff (!rst_n)
    !unlockQ |=> ($stable(prShadow) && $stable(rlShadow)));

  // R7: a pending handoff freezes the value being handed over
  a_r7_pr_busy_hold: assert property (@(posedge busClk) disable iff (!rst_n)
    prBusy |=> $stable(prShadow));
  a_r7_rl_busy_hold: assert property (@(posedge busClk) disable iff (!rst_n)
    rlBusy |=> $stable(rlShadow));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int PR_W        = 3,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_DIV_LOG = 2,
  parameter int MAX_CODE    = 6
) (
  input  logic             wdClk,
  input  logic             rst_n,
  input  wdtXfer_t         xfer,
  input  logic [PR_W-1:0]  prVal,
  input  logic [CNT_W-1:0] rlVal,
  input  logic             hwStart,
  input  logic             dbgFreeze,
  input  logic             coreHalted,
  output logic             prAck,
  output logic             rlAck,
  output logic             wdReset,
  output logic             oscReq
);
  localparam int DIV_W = MIN_DIV_LOG + MAX_CODE + 1;
  localparam int NCMD  = 4;
  localparam int B_START = 3;
  localparam int B_KICK  = 2;
  localparam int B_PR    = 1;
  localparam int B_RL    = 0;

  logic [NCMD-1:0]  cmdLvl;
  logic [NCMD-1:0]  syncQ [SYNC_STAGES];
  logic [NCMD-1:0]  seenQ;
  logic [NCMD-1:0]  pulse;
  logic             startPulse, kickPulse;
  logic             startedQ;
  logic [PR_W-1:0]  prCore;
  logic [PR_W-1:0]  codeEff;
  logic [CNT_W-1:0] rlCore;
  logic [CNT_W-1:0] cntQ;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLast;
  logic             frozen;
  logic             run;

  assign cmdLvl = {xfer.startTgl, xfer.kickTgl, xfer.prTgl, xfer.rlTgl};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge wdClk or negedge rst_n)
        if (!rst_n) syncQ[s] <= '0;
        else        syncQ[s] <= cmdLvl;
    end else begin : g_next
      always_ff @(posedge wdClk or negedge rst_n)
        if (!rst_n) syncQ[s] <= '0;
        else        syncQ[s] <= syncQ[s-1];
    end
  end

  always_ff @(posedge wdClk or negedge rst_n)
    if (!rst_n) seenQ <= '0;
    else        seenQ <= syncQ[SYNC_STAGES-1];

  assign pulse      = syncQ[SYNC_STAGES-1] ^ seenQ;
  assign startPulse = pulse[B_START];
  assign kickPulse  = pulse[B_KICK];
  assign prAck      = seenQ[B_PR];
  assign rlAck      = seenQ[B_RL];

  // Captured copies; the bus side holds its value until the ack returns.
  always_ff @(posedge wdClk or negedge rst_n) begin
    if (!rst_n) begin
      prCore   <= '0;
      rlCore   <= '1;
      startedQ <= 1'b0;
    end else begin
      if (pulse[B_PR]) prCore <= prVal;
      if (pulse[B_RL]) rlCore <= rlVal;
      if (startPulse || hwStart) startedQ <= 1'b1;
    end
  end

  assign codeEff = (prCore > PR_W'(MAX_CODE)) ? PR_W'(MAX_CODE) : prCore;
  assign divLast = (DIV_W'(1) << (int'(codeEff) + MIN_DIV_LOG)) - DIV_W'(1);
  assign frozen  = dbgFreeze & coreHalted;
  assign run     = startedQ & ~frozen;

  always_ff @(posedge wdClk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ   <= '1;
      divCnt <= '0;
    end else if (kickPulse) begin
      cntQ   <= rlCore;
      divCnt <= '0;
    end else if (run) begin
      if (divCnt >= divLast) begin
        divCnt <= '0;
        if (cntQ != '0) cntQ <= cntQ - CNT_W'(1);
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  assign wdReset = startedQ && (cntQ == '0);
  assign oscReq  = startedQ;

  // R2: a started watchdog stays started until reset
  a_r2_sticky_start: assert property (@(posedge wdClk) disable iff (!rst_n)
    startedQ |=> startedQ);

  // R5: outside a refresh the count only ever steps down by one
  a_r5_count_step: assert property (@(posedge wdClk) disable iff (!rst_n)
    (!$past(kickPulse) && (cntQ != $past(cntQ))) |-> (cntQ == $past(cntQ) - CNT_W'(1)));

  // R5: without a refresh, zero is terminal
  a_r5_zero_holds: assert property (@(posedge wdClk) disable iff (!rst_n)
    ((cntQ == '0) && !kickPulse) |=> (cntQ == '0));

  // R8: freeze with the core halted holds the count
  a_r8_freeze_hold: assert property (@(posedge wdClk) disable iff (!rst_n)
    ($past(frozen) && !$past(kickPulse)) |-> $stable(cntQ));
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int PR_W        = 3,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_DIV_LOG = 2,
  parameter int MAX_CODE    = 6,
  parameter int DATA_W      = 32
) (
  input  logic              busClk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              wdClk,
  input  logic              hwStart,
  input  logic              dbgFreeze,
  input  logic              coreHalted,
  output logic              wdReset,
  output logic              oscReq
);
  wdtXfer_t         xfer;
  logic [PR_W-1:0]  prVal;
  logic [CNT_W-1:0] rlVal;
  logic             prAck;
  logic             rlAck;

  wdt_regs #(
    .CNT_W(CNT_W), .PR_W(PR_W), .SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)
  ) u_regs (
    .busClk(busClk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .prAck(prAck), .rlAck(rlAck), .xfer(xfer), .prVal(prVal), .rlVal(rlVal)
  );

  wdt_core #(
    .CNT_W(CNT_W), .PR_W(PR_W), .SYNC_STAGES(SYNC_STAGES),
    .MIN_DIV_LOG(MIN_DIV_LOG), .MAX_CODE(MAX_CODE)
  ) u_core (
    .wdClk(wdClk), .rst_n(rst_n), .xfer(xfer), .prVal(prVal), .rlVal(rlVal),
    .hwStart(hwStart), .dbgFreeze(dbgFreeze), .coreHalted(coreHalted),
    .prAck(prAck), .rlAck(rlAck), .wdReset(wdReset), .oscReq(oscReq)
  );
endmodule

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
  localparam int BUS_PERIOD = 10;
  localparam int WD_HALF    = 20;
  localparam int WATCHDOG_CYCLES = 190000;

  logic        busClk = 1'b0;
  logic        wdClk  = 1'b0;
  logic        rst_n  = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr  = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        hwStart = 1'b0;
  logic        dbgFreeze = 1'b0;
  logic        coreHalted = 1'b0;
  logic        wdReset;
  logic        oscReq;

  int nTests = 0;
  int nFails = 0;

  wdt_top dut (
    .busClk(busClk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .wdClk(wdClk), .hwStart(hwStart), .dbgFreeze(dbgFreeze),
    .coreHalted(coreHalted), .wdReset(wdReset), .oscReq(oscReq)
  );

  always #(BUS_PERIOD/2) busClk = ~busClk;
  initial begin
    #7;
    forever #(WD_HALF) wdClk = ~wdClk;
  end

  task automatic chkEq(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkRange(input string req, input int act, input int lo, input int hi);
    nTests++;
    if (act < lo || act > hi) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic doReset(input logic strap);
    hwStart = strap;
    dbgFreeze = 1'b0;
    coreHalted = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge busClk);
    rst_n = 1'b1;
    @(negedge busClk);
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge busClk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge busClk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output int d);
    @(negedge busClk);
    busAddr = a; busSel = 1'b1; busWr = 1'b0;
    #1;
    d = int'(busRdata);
    busSel = 1'b0;
  endtask

  task automatic waitIdle(output int n);
    int sr;
    n = 0;
    busRead(4'hC, sr);
    while (sr != 0 && n < 200) begin
      n++;
      busRead(4'hC, sr);
    end
  endtask

  task automatic measure(input int limit, output int n);
    n = 0;
    while (!wdReset && n < limit) begin
      @(negedge wdClk);
      n++;
    end
  endtask

  task automatic cfgTimer(input int code, input int rl);
    int n;
    busWrite(4'h0, 32'h5555);
    busWrite(4'h4, code);
    busWrite(4'h8, rl);
    waitIdle(n);
  endtask

  task automatic runTimed(input int code, input int rl, input string req);
    int div, n;
    div = 4 << ((code > 6) ? 6 : code);
    doReset(1'b0);
    busWrite(4'h0, 32'hCCCC);
    cfgTimer(code, rl);
    busWrite(4'h0, 32'hAAAA);
    measure(rl * div + 40, n);
    chkRange(req, n, rl * div, rl * div + 8);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge busClk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    int v, n;
    bit saw;

    // R1: reset state
    doReset(1'b0);
    busRead(4'h0, v); chkEq("R1 key read", v, 0);
    busRead(4'h4, v); chkEq("R1 prescaler read", v, 0);
    busRead(4'h8, v); chkEq("R1 reload read", v, 'hFFF);
    busRead(4'hC, v); chkEq("R1 status read", v, 0);
    chkEq("R1 wdReset low", int'(wdReset), 0);
    chkEq("R1 oscReq low", int'(oscReq), 0);

    // R3 and R10: lock behaviour
    busWrite(4'h8, 32'h123);
    busRead(4'h8, v); chkEq("R3 locked reload write ignored", v, 'hFFF);
    busWrite(4'h0, 32'h5555);
    busWrite(4'h0, 32'hAAAA);
    busWrite(4'h4, 32'h3);
    busRead(4'h4, v); chkEq("R3 refresh key closes lock", v, 0);
    busWrite(4'h0, 32'hFFFF5555);
    busWrite(4'h8, 32'h123);
    waitIdle(n);
    busRead(4'h8, v); chkEq("R10 low-half unlock", v, 'h123);
    busRead(4'h0, v); chkEq("R10 key reads zero", v, 0);

    // R7: busy flags and blocked writes
    busWrite(4'h4, 32'h2);
    busRead(4'hC, v); chkEq("R7 prescaler busy set", v & 3, 1);
    busWrite(4'h4, 32'h5);
    waitIdle(n);
    chkRange("R7 prescaler busy clears", n, 0, 40);
    busRead(4'h4, v); chkEq("R7 write during busy ignored", v, 2);
    busWrite(4'h8, 32'h7);
    busRead(4'hC, v); chkEq("R7 reload busy set", v & 3, 2);
    waitIdle(n);
    chkRange("R7 reload busy clears", n, 0, 40);

    // R5 and R6: every prescaler code, then other reload values
    for (int c = 0; c < 8; c++) runTimed(c, 3, $sformatf("R6 code %0d timeout", c));
    runTimed(1, 1, "R5 reload 1 timeout");
    runTimed(1, 7, "R5 reload 7 timeout");
    busRead(4'h4, v); chkEq("R6 code read back", v, 1);

    // R2: not running before the start key
    doReset(1'b0);
    cfgTimer(0, 3);
    busWrite(4'h0, 32'hAAAA);
    repeat (100) @(negedge wdClk);
    chkEq("R2 no count before start", int'(wdReset), 0);
    chkEq("R2 oscReq low before start", int'(oscReq), 0);
    busWrite(4'h0, 32'hCCCC);
    measure(60, n);
    chkRange("R2 starts on key", n, 10, 20);

    // R2: other keys do not stop it
    doReset(1'b0);
    busWrite(4'h0, 32'hCCCC);
    cfgTimer(0, 5);
    busWrite(4'h0, 32'hAAAA);
    busWrite(4'h0, 32'h0);
    busWrite(4'h0, 32'h1234);
    busWrite(4'h0, 32'hCCCC);
    measure(60, n);
    chkRange("R2 keeps counting", n, 14, 28);
    chkEq("R2 oscReq stays high", int'(oscReq), 1);

    // R4: periodic refresh keeps the reset low
    doReset(1'b0);
    busWrite(4'h0, 32'hCCCC);
    cfgTimer(0, 3);
    saw = 1'b0;
    for (int k = 0; k < 30; k++) begin
      busWrite(4'h0, 32'hAAAA);
      for (int j = 0; j < 16; j++) begin
        @(negedge busClk);
        if (wdReset) saw = 1'b1;
      end
    end
    chkEq("R4 refresh holds off reset", int'(saw), 0);
    measure(40, n);
    chkRange("R4 fires after refreshes stop", n, 1, 16);

    // R8: freeze with halt holds; either alone does not
    doReset(1'b0);
    dbgFreeze = 1'b1; coreHalted = 1'b1;
    busWrite(4'h0, 32'hCCCC);
    cfgTimer(0, 3);
    busWrite(4'h0, 32'hAAAA);
    repeat (200) @(negedge wdClk);
    chkEq("R8 frozen no reset", int'(wdReset), 0);
    @(negedge wdClk);
    dbgFreeze = 1'b0; coreHalted = 1'b0;
    measure(60, n);
    chkRange("R8 resumes after freeze", n, 12, 14);

    doReset(1'b0);
    dbgFreeze = 1'b1;
    busWrite(4'h0, 32'hCCCC);
    cfgTimer(0, 3);
    busWrite(4'h0, 32'hAAAA);
    measure(60, n);
    chkRange("R8 freeze without halt counts", n, 12, 20);

    doReset(1'b0);
    coreHalted = 1'b1;
    busWrite(4'h0, 32'hCCCC);
    cfgTimer(0, 3);
    busWrite(4'h0, 32'hAAAA);
    measure(60, n);
    chkRange("R8 halt without freeze counts", n, 12, 20);

    // R9: strap start
    doReset(1'b1);
    repeat (3) @(negedge wdClk);
    chkEq("R9 strap raises oscReq", int'(oscReq), 1);
    measure(16500, n);
    chkRange("R9 strap timeout", n, 16365, 16392);
    hwStart = 1'b0;

    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule